// File: doc/BRIEF.md
# Flash Command and Interrupt Register File

This block is the register front end of a NAND-style flash controller. A host issues single-cycle 16-bit register reads and writes to a small map holding a command register, two configuration registers, a controller-status register with four error flags, an interrupt-status register and a start-buffer register that picks the buffer and the number of sectors for the next transfer. Reads are combinational and have no wait states.

An accepted command with a recognised code raises a one-cycle strobe toward the flash core, with the command word alongside it. The core later reports completion as a kind code plus an error flag, and the block turns this into interrupt-status and error bits. While the master interrupt bit is set, new commands are refused. Software clears interrupt bits by writing an AND mask, and clearing the master bit also wipes the error flags. The interrupt output's polarity and the ready output both come from the first configuration register. A reset-type completion restores the warm-reset values.

Top module: `flash_regfile`

## Requirements
- R1: After cold reset (rst_n low), reads return configuration-1 = 0x40C0, configuration-2 = 0, status = 0, interrupt status = 0x8080 and write-protect status = 0x0002.
- R2: A write to interrupt status (offset 4) stores the current value ANDed with the written value. Software can clear bits but never set them.
- R3: When bit 15 of interrupt status is 0 after such a write, status bits 13:10 are cleared. Otherwise they are kept.
- R4: A command write (offset 0) is ignored while interrupt status bit 15 is 1. When it is accepted, the command register takes the written word. If the code is recognised, cmd_stb is high for exactly one cycle, starting the cycle after the write, and cmd_code shows the word.
- R5: irq equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6, and it follows every change to either one.
- R6: rdy follows configuration-1 bit 7. Reads of configuration-1 (offset 1) return bits 4:0 as zero.
- R7: A completion with core_kind 2 (erase), 3 (program) or 4 (load) sets interrupt bit 15 plus bit 5, 6 or 7 respectively. core_kind 0 sets only bit 15.
- R8: A completion with core_err set also sets status bit 10 (command error), plus bit 11 for erase, bit 12 for program or bit 13 for load.
- R9: An accepted command whose word is not one of 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0xF0, 0xF3 or 0x65 raises no strobe, and it sets status bit 10 and interrupt bit 15.
- R10: A completion with core_kind 1 (reset) gives the warm-reset values: interrupt status = 0x8010, configuration-1 = 0x40C0, and command, configuration-2, status and start-buffer all 0.
- R11: Start-buffer (offset 5): written bits 11:8 drive buf_sel, and bits 1:0 give sec_count, where 0 means 4. Reads return only those bits.
- R12: Register map: 0 command, 1 configuration-1, 2 configuration-2, 3 status, 4 interrupt, 5 start-buffer, 6 write-protect status. Writes to offsets 3 and 6 are ignored, and reads of other offsets or with rd_en low return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | ADDR_W | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| cmd_stb | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 16 | Last accepted command word |
| core_done | input | 1 | Core completion pulse |
| core_kind | input | 3 | Completion kind: 0 none, 1 reset, 2 erase, 3 program, 4 load |
| core_err | input | 1 | Completion failed |
| buf_sel | output | 4 | Selected buffer |
| sec_count | output | 3 | Sector count, 1 to 4 |
| irq | output | 1 | Interrupt output |
| rdy | output | 1 | Ready output |

## Verification
The bench tries to set interrupt bits through the AND mask, writes 0xFFFF to the interrupt register, and issues commands while the master bit is still set. A design that ORed the mask or skipped the lockout would show bits that should stay clear, or a stray strobe. Error flags are cleared in two steps: first with the master bit kept, then with it cleared. A design that cleared them early, or never, would report the wrong status. The bench also covers an unrecognised code, a count field of 0 that must read as four sectors, polarity flips of the interrupt output, and a reset completion that must restore 0x8010 rather than the cold value.

// File: rtl/flash_regfile.sv
module flash_regfile #(
  parameter int          ADDR_W    = 4,
  parameter logic [15:0] CFG1_INIT = 16'h40C0,
  parameter logic [15:0] WP_INIT   = 16'h0002,
  parameter logic [15:0] INT_COLD  = 16'h8080,
  parameter logic [15:0] INT_WARM  = 16'h8010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              cmd_stb,
  output logic [15:0]       cmd_code,
  input  logic              core_done,
  input  logic [2:0]        core_kind,
  input  logic              core_err,
  output logic [3:0]        buf_sel,
  output logic [2:0]        sec_count,
  output logic              irq,
  output logic              rdy
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SBUF = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_WP   = ADDR_W'(6);
  localparam logic [2:0] K_RST = 3'd1, K_ERS = 3'd2, K_PRG = 3'd3, K_LD = 3'd4;

  logic [15:0] cfg1_q, cfg2_q, int_q, int_n;
  logic [3:0]  err_q, err_n;
  logic [3:0]  bsel_q;
  logic [1:0]  cnt_q;
  logic        known;

  wire wr_cmd   = wr_en && addr == A_CMD;
  wire cmd_take = wr_cmd && !int_q[15];
  wire warm     = core_done && core_kind == K_RST;

  always_comb begin
    case (wdata)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030,
      16'h00F0, 16'h00F3, 16'h0065: known = 1'b1;
      default:                      known = 1'b0;
    endcase
  end

  always_comb begin
    int_n = int_q;
    err_n = err_q;
    if (wr_en && addr == A_INT) begin
      int_n = int_q & wdata;
      if (!int_n[15]) err_n = '0;
    end
    if (cmd_take && !known) begin
      int_n[15] = 1'b1;
      err_n[0]  = 1'b1;
    end
    if (core_done) begin
      int_n[15] = 1'b1;
      case (core_kind)
        K_ERS:   int_n[5] = 1'b1;
        K_PRG:   int_n[6] = 1'b1;
        K_LD:    int_n[7] = 1'b1;
        default: ;
      endcase
      if (core_err) begin
        err_n[0] = 1'b1;
        case (core_kind)
          K_ERS:   err_n[1] = 1'b1;
          K_PRG:   err_n[2] = 1'b1;
          K_LD:    err_n[3] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_code <= '0;
      cfg1_q   <= CFG1_INIT;
      cfg2_q   <= '0;
      int_q    <= INT_COLD;
      err_q    <= '0;
      bsel_q   <= '0;
      cnt_q    <= '0;
    end else if (warm) begin
      cmd_stb  <= 1'b0;
      cmd_code <= '0;
      cfg1_q   <= CFG1_INIT;
      cfg2_q   <= '0;
      int_q    <= INT_WARM;
      err_q    <= '0;
      bsel_q   <= '0;
      cnt_q    <= '0;
    end else begin
      cmd_stb <= cmd_take && known;
      if (cmd_take) cmd_code <= wdata;
      if (wr_en && addr == A_CFG1) cfg1_q <= wdata;
      if (wr_en && addr == A_CFG2) cfg2_q <= wdata;
      if (wr_en && addr == A_SBUF) begin
        bsel_q <= wdata[11:8];
        cnt_q  <= wdata[1:0];
      end
      int_q <= int_n;
      err_q <= err_n;
    end
  end

  assign buf_sel   = bsel_q;
  assign sec_count = (cnt_q == 2'd0) ? 3'd4 : {1'b0, cnt_q};
  assign rdy       = cfg1_q[7];
  assign irq       = int_q[15] ^ ~cfg1_q[6];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CMD:   rdata = cmd_code;
        A_CFG1:  rdata = {cfg1_q[15:5], 5'b0};
        A_CFG2:  rdata = cfg2_q;
        A_STAT:  rdata = {2'b0, err_q, 10'b0};
        A_INT:   rdata = int_q;
        A_SBUF:  rdata = {4'b0, bsel_q, 6'b0, cnt_q};
        A_WP:    rdata = WP_INIT;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_regfile_chk.sv
module flash_regfile_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic              cmd_stb,
  input logic              core_done,
  input logic [2:0]        core_kind,
  input logic              irq,
  input logic              rdy,
  input logic [15:0]       int_q,
  input logic [3:0]        err_q,
  input logic [15:0]       cfg1_q
);
  localparam logic [ADDR_W-1:0] C_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] C_CFG1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] C_INT  = ADDR_W'(4);

  // R2
  int_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_INT && !core_done) |=> ((int_q & ~$past(int_q)) == 16'h0));

  // R3
  err_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_INT && !(int_q[15] && wdata[15]) && !core_done) |=> (err_q == 4'h0));

  // R4
  cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_CMD && int_q[15]) |=> !cmd_stb);

  // R4
  stb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_en && addr == C_CMD && !int_q[15]));

  // R5
  irq_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg1_q[6]) && $stable(int_q)) |-> (irq != $past(irq)));

  // R6
  rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_CFG1 && !(core_done && core_kind == 3'd1)) |=> (rdy == $past(wdata[7])));

  // R10
  warm_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && core_kind == 3'd1) |=> (int_q == 16'h8010 && err_q == 4'h0));
endmodule

bind flash_regfile flash_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cmd_stb(cmd_stb), .core_done(core_done), .core_kind(core_kind),
  .irq(irq), .rdy(rdy), .int_q(int_q), .err_q(err_q), .cfg1_q(cfg1_q)
);

// File: tb/sim_flash_regfile.sv
`timescale 1ns/1ps
module sim_flash_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_wr = 1'b0, b_rd = 1'b0;
  logic [3:0] b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic core_done = 1'b0, core_err = 1'b0;
  logic [2:0] core_kind = '0;
  logic [15:0] rdata, cmd_code;
  logic cmd_stb, irq, rdy;
  logic [3:0] buf_sel;
  logic [2:0] sec_count;

  always #2 clk = ~clk;

  flash_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
    .wdata(b_wdata), .rdata(rdata), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .core_done(core_done), .core_kind(core_kind), .core_err(core_err),
    .buf_sel(buf_sel), .sec_count(sec_count), .irq(irq), .rdy(rdy)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int known_codes[$] = '{'h00, 'h13, 'h80, 'h1A, 'h1B, 'h23, 'h27, 'h2A, 'h2C,
                         'h71, 'h94, 'h95, 'hB0, 'h30, 'hF0, 'hF3, 'h65};
  logic [15:0] m_code, m_cfg1, m_cfg2, m_st, m_int, m_sb, n_int, n_st;
  logic m_stb;

  function automatic bit is_known(input logic [15:0] w);
    foreach (known_codes[i]) if (int'(w) == known_codes[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] mread(input logic rd, input logic [3:0] a);
    if (!rd) return 16'h0;
    case (a)
      4'd0: return m_code;
      4'd1: return m_cfg1 & 16'hFFE0;
      4'd2: return m_cfg2;
      4'd3: return m_st;
      4'd4: return m_int;
      4'd5: return m_sb;
      4'd6: return 16'h0002;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_init(input logic [15:0] iv);
    m_code = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_st = 0; m_int = iv; m_sb = 0; m_stb = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_init(16'h8080);
    else if (core_done && core_kind == 3'd1) model_init(16'h8010);
    else begin
      n_int = m_int; n_st = m_st;
      m_stb = 1'b0;
      if (b_wr && b_addr == 4'd4) begin
        n_int = m_int & b_wdata;
        if (n_int[15] == 1'b0) n_st = 16'h0;
      end
      if (b_wr && b_addr == 4'd0 && m_int[15] == 1'b0) begin
        m_code = b_wdata;
        if (is_known(b_wdata)) m_stb = 1'b1;
        else begin n_int = n_int | 16'h8000; n_st = n_st | 16'h0400; end
      end
      if (core_done) begin
        n_int = n_int | 16'h8000;
        if (core_kind == 3'd2) n_int = n_int | 16'h0020;
        if (core_kind == 3'd3) n_int = n_int | 16'h0040;
        if (core_kind == 3'd4) n_int = n_int | 16'h0080;
        if (core_err) begin
          n_st = n_st | 16'h0400;
          if (core_kind == 3'd2) n_st = n_st | 16'h0800;
          if (core_kind == 3'd3) n_st = n_st | 16'h1000;
          if (core_kind == 3'd4) n_st = n_st | 16'h2000;
        end
      end
      if (b_wr && b_addr == 4'd1) m_cfg1 = b_wdata;
      if (b_wr && b_addr == 4'd2) m_cfg2 = b_wdata;
      if (b_wr && b_addr == 4'd5) m_sb = b_wdata & 16'h0F03;
      m_int = n_int; m_st = n_st;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R4 strobe", {15'h0, cmd_stb}, {15'h0, m_stb});
      chk("R4 code", cmd_code, m_code);
      chk("R5 irq", {15'h0, irq}, {15'h0, m_int[15] ^ ~m_cfg1[6]});
      chk("R6 rdy", {15'h0, rdy}, {15'h0, m_cfg1[7]});
      chk("R11 buf_sel", {12'h0, buf_sel}, {12'h0, m_sb[11:8]});
      chk("R11 sec_count", {13'h0, sec_count}, (m_sb[1:0] == 2'd0) ? 16'd4 : {14'h0, m_sb[1:0]});
      chk("R12 rdata", rdata, mread(b_rd, b_addr));
    end
  end

  // core stub
  bit stub_err = 1'b0;
  int pend = 0;
  logic [2:0] pend_kind = '0;
  logic pend_err = 1'b0;

  function automatic logic [2:0] kind_of(input logic [15:0] c);
    case (c)
      16'h00F0, 16'h00F3:                      return 3'd1;
      16'h0094, 16'h0095, 16'h0030:            return 3'd2;
      16'h0080, 16'h001A, 16'h001B:            return 3'd3;
      16'h0000, 16'h0013:                      return 3'd4;
      default:                                 return 3'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    core_done = 1'b0;
    if (pend == 1) begin
      core_done = 1'b1; core_kind = pend_kind; core_err = pend_err;
    end
    if (pend > 0) pend--;
    if (cmd_stb) begin
      pend = 2; pend_kind = kind_of(cmd_code); pend_err = stub_err;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(posedge clk); #1;
    b_wr = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(posedge clk); #1;
    b_rd = 1'b1; b_addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
    @(posedge clk); #1;
    b_rd = 1'b0;
  endtask

  task automatic docmd(input logic [15:0] c);
    wr(4'd0, c);
    repeat (6) @(posedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 cold reset values
    rdchk("R1 cfg1", 4'd1, 16'h40C0);
    rdchk("R1 cfg2", 4'd2, 16'h0000);
    rdchk("R1 status", 4'd3, 16'h0000);
    rdchk("R1 int", 4'd4, 16'h8080);
    rdchk("R1 wp", 4'd6, 16'h0002);
    chk("R11 reset count", {13'h0, sec_count}, 16'd4);
    // R4 lockout while bit 15 set
    docmd(16'h0094);
    rdchk("R4 locked cmd", 4'd0, 16'h0000);
    // R2 AND mask
    wr(4'd4, 16'hFFFF);
    rdchk("R2 no set", 4'd4, 16'h8080);
    wr(4'd4, 16'h7FFF);
    rdchk("R2 and", 4'd4, 16'h0080);
    wr(4'd4, 16'h0000);
    // R7 load completion
    docmd(16'h0013);
    rdchk("R7 load", 4'd4, 16'h8080);
    chk("R5 irq active", {15'h0, irq}, 16'h1);
    wr(4'd4, 16'h0000);
    // R8 program error, R3 staged clear
    stub_err = 1'b1;
    docmd(16'h0080);
    rdchk("R7 prog", 4'd4, 16'h8040);
    rdchk("R8 prog err", 4'd3, 16'h1400);
    wr(4'd4, 16'h8000);
    rdchk("R3 kept", 4'd3, 16'h1400);
    wr(4'd4, 16'h0000);
    rdchk("R3 wiped", 4'd3, 16'h0000);
    // R8 erase error
    docmd(16'h0094);
    rdchk("R7 erase", 4'd4, 16'h8020);
    rdchk("R8 erase err", 4'd3, 16'h0C00);
    wr(4'd4, 16'h0000);
    stub_err = 1'b0;
    // R7 none kind
    docmd(16'h0023);
    rdchk("R7 none", 4'd4, 16'h8000);
    wr(4'd4, 16'h0000);
    // R9 unknown code
    docmd(16'h0055);
    rdchk("R9 int", 4'd4, 16'h8000);
    rdchk("R9 status", 4'd3, 16'h0400);
    rdchk("R9 cmd", 4'd0, 16'h0055);
    wr(4'd4, 16'h0000);
    // R5 / R6 configuration
    wr(4'd1, 16'h0000);
    chk("R6 rdy low", {15'h0, rdy}, 16'h0);
    chk("R5 inverted idle", {15'h0, irq}, 16'h1);
    rdchk("R6 cfg1 zero", 4'd1, 16'h0000);
    wr(4'd1, 16'h00DF);
    rdchk("R6 cfg1 mask", 4'd1, 16'h00C0);
    chk("R6 rdy high", {15'h0, rdy}, 16'h1);
    chk("R5 normal idle", {15'h0, irq}, 16'h0);
    // R11 start-buffer
    wr(4'd5, 16'h0A03);
    chk("R11 sel", {12'h0, buf_sel}, 16'hA);
    chk("R11 cnt3", {13'h0, sec_count}, 16'd3);
    rdchk("R11 read", 4'd5, 16'h0A03);
    wr(4'd5, 16'h0500);
    chk("R11 cnt0 as 4", {13'h0, sec_count}, 16'd4);
    wr(4'd5, 16'hFFFE);
    rdchk("R11 masked", 4'd5, 16'h0F02);
    // R12 map behaviour
    wr(4'd2, 16'h1234);
    rdchk("R12 cfg2", 4'd2, 16'h1234);
    wr(4'd3, 16'hFFFF);
    rdchk("R12 status ro", 4'd3, 16'h0000);
    wr(4'd6, 16'h0000);
    rdchk("R12 wp ro", 4'd6, 16'h0002);
    rdchk("R12 unmapped", 4'd15, 16'h0000);
    // R10 warm reset via reset command
    docmd(16'h00F0);
    rdchk("R10 int", 4'd4, 16'h8010);
    rdchk("R10 cfg1", 4'd1, 16'h40C0);
    rdchk("R10 cfg2", 4'd2, 16'h0000);
    rdchk("R10 sbuf", 4'd5, 16'h0000);
    rdchk("R10 cmd", 4'd0, 16'h0000);
    // R4 lockout after warm reset
    docmd(16'h0080);
    rdchk("R4 locked again", 4'd0, 16'h0000);
    repeat (4) @(posedge clk);
    finish_up();
  end
endmodule